// File: doc/BRIEF.md
# Port Pin Control Register Bank

This block holds one 32-bit control register for each pin of an I/O port. Software reaches it over a simple single-master memory-mapped bus with 32-bit data and byte strobes. The lower halfword of every register drives that pin's configuration to the pad logic at all times.

Each pin register sits at its own word address and can be read and written directly. Above the pin registers sit broadcast registers, one for each group of 16 pins. A single full-word write to one of them carries a 16-bit selection mask in its upper half and a 16-bit value in its lower half. That value is copied into the lower halfword of every selected pin register in the group, all in the same clock.

Bit 15 of a pin register is a lock. Once it is set, the register refuses every later write, direct or broadcast, until reset. Each register makes that decision on its own, so one broadcast can update some targets while locked targets keep their value.

Top module: `pin_ctl_bank`

## Requirements
- R1: After reset every pin register reads 0x0000_0000, every pin is unlocked and `pin_cfg` is all zero.
- R2: A write to byte address 4*n (n = 0..31) updates only the byte lanes of register n whose strobe bit is 1. `bus_strb[k]` controls bits [8k+7:8k]. A read of 4*n returns the register, combinationally in the same cycle.
- R3: A full-strobe write to address 0x80 copies `bus_wdata[15:0]` into bits [15:0] of pin register i (i = 0..15) for every i with `bus_wdata[16+i]` = 1. Bits [31:16] of those registers are left unchanged.
- R4: A full-strobe write to address 0x84 does the same for pin registers 16+i, selected by `bus_wdata[16+i]`.
- R5: Pin registers not selected by a broadcast write, and all registers outside the addressed group, keep their value.
- R6: A register with bit 15 set ignores direct and broadcast writes until the next reset. Unlocked registers selected in the same broadcast are still updated. The lock bit can be set through either path.
- R7: A write to 0x80 or 0x84 whose `bus_strb` is not 4'b1111 changes no register.
- R8: Reads of 0x80 and 0x84 return zero. So do reads of any address from 0x88 upward and of any address with `bus_addr[1:0]` not zero. Writes to any of these addresses change nothing.
- R9: `pin_cfg[16n+15:16n]` always equals bits [15:0] of pin register n. It changes on the clock edge that accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the port |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes for writes |
| bus_rdata | output | 32 | Read data, valid during a read access |
| pin_cfg | output | 512 | Lower halfword of every pin register, pin n at [16n+15:16n] |

## Verification
The assertions take for granted that reset is held at the start of the run. They also assume that at most one access arrives per clock, so a direct write and a broadcast never target the same register together. Byte strobes are only read during writes.

The bench changes every bus input on the falling clock edge and presents one access at a time. It checks reads and `pin_cfg` half a cycle after the edge that performed the write. It deliberately sends partial strobes and misaligned and unmapped addresses, so that each ignore rule is exercised inside these assumptions.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
   localparam int REG_W    = 32;
   localparam int HALF_W   = 16;
   localparam int STRB_W   = REG_W / 8;
   localparam int LOCK_BIT = 15;
   localparam int GRP_SZ   = 16;

   typedef struct packed {
      logic              dir_we;
      logic [STRB_W-1:0] dir_strb;
      logic              glb_we;
      logic [HALF_W-1:0] glb_data;
   } pin_wr_t;
endpackage

// File: rtl/pcb_decode.sv
`timescale 1ns/1ps
module pcb_decode #(
   parameter int NUM_PINS   = 32,
   parameter int ADDR_W     = 8,
   parameter bit BYTE_LANES = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_valid,
   input  logic                       bus_write,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [pcb_pkg::REG_W-1:0]  bus_wdata,
   input  logic [pcb_pkg::STRB_W-1:0] bus_strb,
   output pcb_pkg::pin_wr_t           cmd [NUM_PINS],
   output logic                       rd_hit,
   output logic [$clog2(NUM_PINS)-1:0] rd_idx
);
   import pcb_pkg::*;

   localparam int WORD_W = ADDR_W - 2;
   localparam int NGRP   = NUM_PINS / GRP_SZ;
   localparam int IDX_W  = $clog2(NUM_PINS);
   localparam logic [WORD_W-1:0] PIN_LIM = WORD_W'(NUM_PINS);
   localparam logic [WORD_W-1:0] GLB_LIM = WORD_W'(NUM_PINS + NGRP);

   if (NUM_PINS < GRP_SZ || (NUM_PINS % GRP_SZ) != 0) begin : g_chk_pins
      $error("NUM_PINS must be a positive multiple of the group size");
   end
   if ((NUM_PINS + NGRP) * 4 > (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] grp;
   logic              aligned, wr, full, dir_hit, glb_hit;
   logic [STRB_W-1:0] lane_strb;
   logic [NUM_PINS-1:0] dir_vec, glb_vec;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr      = bus_valid & bus_write & aligned;
   assign full    = &bus_strb;
   assign dir_hit = aligned & (word < PIN_LIM);
   assign glb_hit = aligned & (word >= PIN_LIM) & (word < GLB_LIM);
   assign grp     = word - PIN_LIM;
   assign rd_hit  = dir_hit;
   assign rd_idx  = word[IDX_W-1:0];

   if (BYTE_LANES) begin : g_lanes
      assign lane_strb = bus_strb;
   end else begin : g_word_only
      assign lane_strb = {STRB_W{full}};
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign dir_vec[p] = wr & dir_hit & (word == WORD_W'(p)) & (|lane_strb);
      assign glb_vec[p] = wr & full & glb_hit & (grp == WORD_W'(p / GRP_SZ))
                        & bus_wdata[HALF_W + (p % GRP_SZ)];
      assign cmd[p].dir_we   = dir_vec[p];
      assign cmd[p].dir_strb = lane_strb;
      assign cmd[p].glb_we   = glb_vec[p];
      assign cmd[p].glb_data = bus_wdata[HALF_W-1:0];
   end

   // R2: a direct write never reaches more than one register
   p_dir_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dir_vec));
   // R7: a narrow strobe on a broadcast address selects nothing
   p_glb_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_strb != '1) |-> (glb_vec == '0));
   // R5: one broadcast reaches at most one group
   p_glb_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(glb_vec) <= GRP_SZ);
   // R8: misaligned accesses never produce a write
   p_misalign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> (dir_vec == '0 && glb_vec == '0));
endmodule

// File: rtl/pcb_pin_reg.sv
`timescale 1ns/1ps
module pcb_pin_reg (
   input  logic                      clk,
   input  logic                      rst_n,
   input  pcb_pkg::pin_wr_t          cmd,
   input  logic [pcb_pkg::REG_W-1:0] wdata,
   output logic [pcb_pkg::REG_W-1:0] q
);
   import pcb_pkg::*;

   logic locked;
   assign locked = q[LOCK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (!locked) begin
         if (cmd.dir_we) begin
            for (int b = 0; b < STRB_W; b++) begin
               if (cmd.dir_strb[b]) q[8*b +: 8] <= wdata[8*b +: 8];
            end
         end else if (cmd.glb_we) begin
            q[HALF_W-1:0] <= cmd.glb_data;
         end
      end
   end

   // R6: a locked register never changes
   p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(q));
   // R5: no write request, no change
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.dir_we && !cmd.glb_we) |=> $stable(q));
   // R3: a broadcast writes only the lower halfword
   p_glb_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.glb_we && !cmd.dir_we && !locked) |=>
      (q[REG_W-1:HALF_W] == $past(q[REG_W-1:HALF_W]) &&
       q[HALF_W-1:0] == $past(cmd.glb_data)));
endmodule

// File: rtl/pin_ctl_bank.sv
`timescale 1ns/1ps
module pin_ctl_bank #(
   parameter int NUM_PINS   = 32,
   parameter int ADDR_W     = 8,
   parameter bit BYTE_LANES = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_valid,
   input  logic                         bus_write,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [31:0]                  bus_wdata,
   input  logic [3:0]                   bus_strb,
   output logic [31:0]                  bus_rdata,
   output logic [NUM_PINS*16-1:0]       pin_cfg
);
   import pcb_pkg::*;

   localparam int IDX_W = $clog2(NUM_PINS);
   localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(4 * NUM_PINS);

   pin_wr_t          cmd [NUM_PINS];
   logic [REG_W-1:0] regs [NUM_PINS];
   logic             rd_hit;
   logic [IDX_W-1:0] rd_idx;

   pcb_decode #(
      .NUM_PINS  (NUM_PINS),
      .ADDR_W    (ADDR_W),
      .BYTE_LANES(BYTE_LANES)
   ) decode_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_valid(bus_valid),
      .bus_write(bus_write),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_strb (bus_strb),
      .cmd      (cmd),
      .rd_hit   (rd_hit),
      .rd_idx   (rd_idx)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_reg
      pcb_pin_reg reg_i (
         .clk  (clk),
         .rst_n(rst_n),
         .cmd  (cmd[p]),
         .wdata(bus_wdata),
         .q    (regs[p])
      );
      assign pin_cfg[p*HALF_W +: HALF_W] = regs[p][HALF_W-1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write && rd_hit) bus_rdata = regs[rd_idx];
   end

   // R8: broadcast and unmapped addresses read as zero
   p_hi_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr >= MAP_END) |-> (bus_rdata == '0));
   // R9: the pad output agrees with the bus view of the same register
   p_cfg_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && rd_hit) |->
      (bus_rdata[HALF_W-1:0] == pin_cfg[rd_idx*HALF_W +: HALF_W]));
endmodule

// File: tb/pin_ctl_bank_tb_top.sv
`timescale 1ns/1ps
module pin_ctl_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_strb = '0;
   logic [31:0] bus_rdata;
   logic [511:0] pin_cfg;

   logic [31:0] exp_q [32];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pin_ctl_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
      .bus_rdata(bus_rdata), .pin_cfg(pin_cfg)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
      end
   endtask

   task automatic model_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
      if (a[1:0] != 2'b00) return;
      if (a < 8'h80) begin
         if (!exp_q[a[6:2]][15])
            for (int b = 0; b < 4; b++) if (s[b]) exp_q[a[6:2]][8*b +: 8] = d[8*b +: 8];
      end else if ((a == 8'h80 || a == 8'h84) && s == 4'hF) begin
         for (int i = 0; i < 16; i++) begin
            int p;
            p = (a == 8'h84) ? 16 + i : i;
            if (d[16+i] && !exp_q[p][15]) exp_q[p][15:0] = d[15:0];
         end
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_strb = '0;
      model_wr(a, d, s);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic cmp_all(input string tag);
      logic [31:0] v;
      for (int p = 0; p < 32; p++) begin
         rd(8'(p*4), v);
         chk({tag, " read"}, v, exp_q[p]);
         chk("R9 pin_cfg", {16'h0, pin_cfg[p*16 +: 16]}, {16'h0, exp_q[p][15:0]});
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int p = 0; p < 32; p++) exp_q[p] = '0;
   endtask

   initial begin
      logic [31:0] v;
      logic [15:0] masks [6];
      masks[0] = 16'h0001; masks[1] = 16'h8000; masks[2] = 16'hAAAA;
      masks[3] = 16'h5555; masks[4] = 16'hFFFF; masks[5] = 16'h0000;
      do_reset();
      @(negedge clk);
      cmp_all("R1 reset");

      // R2 direct full-word writes, lock bit kept clear
      for (int p = 0; p < 32; p++)
         wr(8'(p*4), ((32'(p) * 32'h01030507) ^ 32'h5A5A_3C3C) & 32'hFFFF_7FFF, 4'hF);
      cmp_all("R2 direct");
      // R2 byte-lane writes
      for (int p = 0; p < 16; p++)
         wr(8'(p*4), 32'hC3A1_7E96 & 32'hFFFF_7FFF, 4'(p));
      cmp_all("R2 lanes");

      // R3, R5 broadcast low sweep
      for (int k = 0; k < 6; k++) begin
         wr(8'h80, {masks[k], 16'(16'h1357 * (k + 1)) & 16'h7FFF}, 4'hF);
         cmp_all("R3 R5 glb low");
      end
      // R4, R5 broadcast high sweep
      for (int k = 0; k < 6; k++) begin
         wr(8'h84, {masks[5-k], 16'(16'h2468 + 16'h0111 * k) & 16'h7FFF}, 4'hF);
         cmp_all("R4 R5 glb high");
      end

      // R7 narrow strobes on broadcast addresses
      wr(8'h80, 32'hFFFF_0F0F, 4'b0111);
      wr(8'h84, 32'hFFFF_0F0F, 4'b1110);
      wr(8'h80, 32'hFFFF_0F0F, 4'b0001);
      cmp_all("R7 narrow");

      // R8 zero reads and ignored writes
      rd(8'h80, v); chk("R8 read 0x80", v, 32'h0);
      rd(8'h84, v); chk("R8 read 0x84", v, 32'h0);
      rd(8'h90, v); chk("R8 read 0x90", v, 32'h0);
      rd(8'hFC, v); chk("R8 read 0xFC", v, 32'h0);
      rd(8'h09, v); chk("R8 read misaligned", v, 32'h0);
      wr(8'h88, 32'hFFFF_1111, 4'hF);
      wr(8'hF0, 32'h1234_5678, 4'hF);
      wr(8'h0A, 32'h0000_7777, 4'hF);
      wr(8'h81, 32'hFFFF_2222, 4'hF);
      cmp_all("R8 ignored");

      // R6 lock through direct path
      wr(8'h14, 32'hABCD_8055, 4'hF);
      wr(8'h14, 32'h0000_0000, 4'hF);
      wr(8'h80, 32'hFFFF_0123, 4'hF);
      cmp_all("R6 lock direct");
      // R6 lock through broadcast path
      wr(8'h84, 32'h0003_8001, 4'hF);
      wr(8'h84, 32'h000F_0002, 4'hF);
      wr(8'h40, 32'h0000_0000, 4'hF);
      wr(8'h44, 32'h1111_0000, 4'b1100);
      cmp_all("R6 lock glb");

      // R1, R6 reset clears the locks
      do_reset();
      @(negedge clk);
      cmp_all("R1 second reset");
      wr(8'h14, 32'h0000_0042, 4'hF);
      wr(8'h84, 32'h0001_0099, 4'hF);
      cmp_all("R6 unlocked after reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule